// File: doc/BRIEF.md
# Multi-Master I2C Byte Engine with Arbitration Watch

This block is a single-byte I2C master meant for a bus that other masters share. On command it produces a Start, a Repeated Start, a Stop, one transmitted byte followed by a sampled acknowledge slot, or a single driven acknowledge bit. It works through two open-drain outputs: a high enable pulls the line low, and a low enable releases it. The true levels of the lines come back on two inputs. Every bit occupies four quarter periods. The length of each quarter is `clk_div + 1` clock cycles. SCL is held low in the first two quarters and released in the last two. SDA is compared against the intended level after a quarter in which SCL is high.

Whenever the engine releases SDA but reads it low, another master has won the bus. The engine then drops both lines, sets a sticky collision flag, clears the buffer-full flag and any pending command, and returns to idle. A separate bus monitor synchronizes both lines, detects Start and Stop conditions from any master, and derives a bus-free indication. A Start request waits in its pending bit until the bus is free and no collision is flagged. After a collision, a Stop seen on the bus raises the event flag, so software learns when it may try again.

Top module: `i2c_mm_master`

## Requirements
- R1: After reset, both open-drain enables are low, `bcol`, `evt`, `buf_full` and `pend` are zero, and `bus_free` is 1.
- R2: A Start request (`pend` bit 0) is issued only while `bus_free` is 1 and `bcol` is 0. Until then it stays pending and the lines stay released. `bus_free` is 1 when the last condition seen was a Stop, or when neither condition has been seen since reset or enable.
- R3: A falling SDA with SCL high sets `start_seen` and clears `stop_seen`. A rising SDA with SCL high does the reverse. This holds for conditions from any master.
- R4: A written byte goes out MSB first, one bit per 4 × (`clk_div`+1) cycles, followed by a ninth slot in which SDA is released. `ack_rcvd` is 1 when SDA was low in that slot.
- R5: If SDA reads low in the third quarter of a data bit that the engine releases, the engine releases both lines, sets `bcol`, clears `buf_full` and `pend`, and leaves bus ownership (`bus_own` 0).
- R6: Arbitration is also checked during a Start or Repeated Start (SDA must read high at the end of the second quarter) and during a released acknowledge bit. Loss aborts the condition and clears `pend`. `pend` bits are: 0 Start, 1 Repeated Start, 2 Stop, 3 Acknowledge.
- R7: While `bcol` is set, or while `stop_irq_en` is 1, a Stop detected on the bus sets `evt`.
- R8: `bcol` stays set until `bcol_clr`. While it is set, no Start is issued.
- R9: The first write after a collision transmits its byte starting from the MSB.
- R10: With `en` low, any transfer ends at once. Both lines are released, and `start_seen`, `stop_seen`, `buf_full`, `pend` and ownership are cleared.
- R11: Successful completion of each command or byte sets `evt`. `evt_clr` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable |
| clk_div | input | DIV_W | Quarter period minus one, in clocks (minimum 2) |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| cmd_start | input | 1 | Request a Start (accepted while idle) |
| cmd_rstart | input | 1 | Request a Repeated Start (while owning the bus) |
| cmd_stop | input | 1 | Request a Stop (while owning the bus) |
| cmd_ack | input | 1 | Send one acknowledge bit (while owning the bus) |
| ack_bit | input | 1 | Level for the acknowledge bit (0 drives low) |
| tx_wr | input | 1 | Load and transmit `tx_data` (while owning the bus) |
| tx_data | input | DATA_W | Byte to transmit |
| stop_irq_en | input | 1 | Set `evt` on any Stop detected on the bus |
| evt_clr | input | 1 | Clear `evt` |
| bcol_clr | input | 1 | Clear `bcol` |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| busy | output | 1 | A condition or bit sequence is in progress |
| bus_own | output | 1 | Engine holds the bus |
| buf_full | output | 1 | Transmit byte in progress |
| ack_rcvd | output | 1 | Last byte was acknowledged |
| bcol | output | 1 | Sticky collision flag |
| evt | output | 1 | Sticky event flag |
| pend | output | 4 | Pending command bits |
| start_seen | output | 1 | Last bus condition was a Start |
| stop_seen | output | 1 | Last bus condition was a Stop |
| bus_free | output | 1 | Bus may be taken |

## Verification
The bench builds the block with `clk_div` = 3, `DATA_W` = 8 and a two-stage synchronizer. That gives quarters of four cycles, which leaves room after the synchronizer delay before each sample point, and a byte takes about 150 cycles. This makes it practical to force a collision at a chosen point: the first address bit, the second quarter of a Start, and a released acknowledge bit. It also allows a full Start–byte–Stop sequence for several data patterns, and lets the bench time the first SCL period directly on the bus.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HELD,
    ST_START,
    ST_RSTART,
    ST_BYTE,
    ST_STOP,
    ST_ACKO
  } eng_st_t;

  localparam int P_START  = 0;
  localparam int P_RSTART = 1;
  localparam int P_STOP   = 2;
  localparam int P_ACK    = 3;
  localparam int PEND_W   = 4;

  localparam logic [1:0] Q_0 = 2'd0;
  localparam logic [1:0] Q_1 = 2'd1;
  localparam logic [1:0] Q_2 = 2'd2;
  localparam logic [1:0] Q_3 = 2'd3;

endpackage

// File: rtl/i2cm_phase_gen.sv
module i2cm_phase_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             qtick,
  output logic [1:0]       q
);

  logic [DIV_W-1:0] cnt, cnt_n;
  logic [1:0]       q_n;

  assign qtick = run && (cnt == div);

  always_comb begin
    cnt_n = cnt;
    q_n   = q;
    if (!run) begin
      cnt_n = '0;
      q_n   = '0;
    end else if (qtick) begin
      cnt_n = '0;
      q_n   = q + 2'd1;
    end else begin
      cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= '0;
    end else begin
      cnt <= cnt_n;
      q   <= q_n;
    end
  end

endmodule

// File: rtl/i2cm_bus_mon.sv
module i2cm_bus_mon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic start_seen,
  output logic stop_seen,
  output logic bus_free
);

  logic [SYNC-1:0] scl_sh, sda_sh;
  logic            scl_s, scl_d, sda_d;
  logic            start_seen_n, stop_seen_n;

  assign scl_s = scl_sh[SYNC-1];
  assign sda_s = sda_sh[SYNC-1];

  assign start_det = scl_s && scl_d && sda_d && !sda_s;
  assign stop_det  = scl_s && scl_d && !sda_d && sda_s;
  assign bus_free  = stop_seen || (!start_seen && !stop_seen);

  always_comb begin
    start_seen_n = start_seen;
    stop_seen_n  = stop_seen;
    if (!en) begin
      start_seen_n = 1'b0;
      stop_seen_n  = 1'b0;
    end else if (start_det) begin
      start_seen_n = 1'b1;
      stop_seen_n  = 1'b0;
    end else if (stop_det) begin
      start_seen_n = 1'b0;
      stop_seen_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh     <= '1;
      sda_sh     <= '1;
      scl_d      <= 1'b1;
      sda_d      <= 1'b1;
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
    end else begin
      scl_sh     <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh     <= {sda_sh[SYNC-2:0], sda_i};
      scl_d      <= scl_s;
      sda_d      <= sda_s;
      start_seen <= start_seen_n;
      stop_seen  <= stop_seen_n;
    end
  end

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 qtick,
  input  logic [1:0]           q,
  input  logic                 sda_s,
  input  logic                 bus_free,
  input  logic                 stop_det,
  input  logic                 cmd_start,
  input  logic                 cmd_rstart,
  input  logic                 cmd_stop,
  input  logic                 cmd_ack,
  input  logic                 ack_bit,
  input  logic                 tx_wr,
  input  logic [DATA_W-1:0]    tx_data,
  input  logic                 stop_irq_en,
  input  logic                 evt_clr,
  input  logic                 bcol_clr,
  output logic                 run,
  output logic                 scl_low,
  output logic                 sda_low,
  output logic                 bus_own,
  output logic                 buf_full,
  output logic                 ack_rcvd,
  output logic                 bcol,
  output logic                 evt,
  output logic [PEND_W-1:0]    pend
);

  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W);

  eng_st_t           st, st_n;
  logic [IDX_W-1:0]  idx, idx_n;
  logic [DATA_W-1:0] sh, sh_n;
  logic [PEND_W-1:0] pend_n;
  logic              bf_n, ackr_n, bcol_n, evt_n, hold, hold_n, ackq, ackq_n;
  logic              coll, done, cur_bit, data_slot;

  assign data_slot = (idx < LAST_IDX);
  assign cur_bit   = data_slot ? sh[DATA_W-1] : 1'b1;
  assign run       = (st != ST_IDLE) && (st != ST_HELD);
  assign bus_own   = (st != ST_IDLE);

  // line drive decode
  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    unique case (st)
      ST_IDLE:   begin scl_low = 1'b0;        sda_low = 1'b0;     end
      ST_HELD:   begin scl_low = 1'b1;        sda_low = hold;     end
      ST_START:  begin scl_low = 1'b0;        sda_low = q[1];     end
      ST_RSTART: begin scl_low = (q == Q_0);  sda_low = q[1];     end
      ST_BYTE:   begin scl_low = !q[1];       sda_low = !cur_bit; end
      ST_STOP:   begin scl_low = (q == Q_0);  sda_low = (q != Q_3); end
      ST_ACKO:   begin scl_low = !q[1];       sda_low = !ackq;    end
      default:   begin scl_low = 1'b0;        sda_low = 1'b0;     end
    endcase
  end

  // next state
  always_comb begin
    st_n   = st;
    idx_n  = idx;
    sh_n   = sh;
    pend_n = pend;
    bf_n   = buf_full;
    ackr_n = ack_rcvd;
    bcol_n = bcol;
    evt_n  = evt && !evt_clr;
    hold_n = hold;
    ackq_n = ackq;
    coll   = 1'b0;
    done   = 1'b0;

    unique case (st)
      ST_IDLE: begin
        if (cmd_start) pend_n[P_START] = 1'b1;
        if (pend[P_START] && bus_free && !bcol) st_n = ST_START;
      end
      ST_HELD: begin
        if (cmd_rstart) begin
          pend_n[P_RSTART] = 1'b1;
          st_n = ST_RSTART;
        end else if (cmd_stop) begin
          pend_n[P_STOP] = 1'b1;
          st_n = ST_STOP;
        end else if (cmd_ack) begin
          pend_n[P_ACK] = 1'b1;
          ackq_n = ack_bit;
          st_n = ST_ACKO;
        end else if (tx_wr) begin
          sh_n  = tx_data;
          idx_n = '0;
          bf_n  = 1'b1;
          st_n  = ST_BYTE;
        end
      end
      ST_START, ST_RSTART: begin
        if (qtick) begin
          if (q == Q_1 && !sda_s) begin
            coll = 1'b1;
          end else if (q == Q_3) begin
            done   = 1'b1;
            hold_n = 1'b1;
            st_n   = ST_HELD;
          end
        end
      end
      ST_BYTE: begin
        if (qtick) begin
          if (q == Q_2) begin
            if (data_slot) begin
              if (cur_bit && !sda_s) coll = 1'b1;
            end else begin
              ackr_n = !sda_s;
            end
          end else if (q == Q_3) begin
            if (!data_slot) begin
              done   = 1'b1;
              bf_n   = 1'b0;
              hold_n = 1'b0;
              st_n   = ST_HELD;
            end else begin
              idx_n = idx + 1'b1;
              sh_n  = {sh[DATA_W-2:0], 1'b0};
            end
          end
        end
      end
      ST_STOP: begin
        if (qtick && q == Q_3) begin
          if (!sda_s) coll = 1'b1;
          else begin
            done = 1'b1;
            st_n = ST_IDLE;
          end
        end
      end
      ST_ACKO: begin
        if (qtick) begin
          if (q == Q_2 && ackq && !sda_s) begin
            coll = 1'b1;
          end else if (q == Q_3) begin
            done   = 1'b1;
            hold_n = 1'b0;
            st_n   = ST_HELD;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase

    if (done) begin
      pend_n = '0;
      evt_n  = 1'b1;
    end
    if (stop_det && (bcol || stop_irq_en)) evt_n = 1'b1;
    if (bcol_clr) bcol_n = 1'b0;

    if (coll) begin
      st_n   = ST_IDLE;
      pend_n = '0;
      bf_n   = 1'b0;
      idx_n  = '0;
      bcol_n = 1'b1;
    end

    if (!en) begin
      st_n   = ST_IDLE;
      idx_n  = '0;
      pend_n = '0;
      bf_n   = 1'b0;
      ackr_n = 1'b0;
      bcol_n = 1'b0;
      evt_n  = 1'b0;
      hold_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      sh       <= '0;
      pend     <= '0;
      buf_full <= 1'b0;
      ack_rcvd <= 1'b0;
      bcol     <= 1'b0;
      evt      <= 1'b0;
      hold     <= 1'b0;
      ackq     <= 1'b0;
    end else begin
      st       <= st_n;
      idx      <= idx_n;
      sh       <= sh_n;
      pend     <= pend_n;
      buf_full <= bf_n;
      ack_rcvd <= ackr_n;
      bcol     <= bcol_n;
      evt      <= evt_n;
      hold     <= hold_n;
      ackq     <= ackq_n;
    end
  end

endmodule

// File: rtl/i2c_mm_master.sv
module i2c_mm_master
  import i2cm_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              cmd_start,
  input  logic              cmd_rstart,
  input  logic              cmd_stop,
  input  logic              cmd_ack,
  input  logic              ack_bit,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              stop_irq_en,
  input  logic              evt_clr,
  input  logic              bcol_clr,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              bus_own,
  output logic              buf_full,
  output logic              ack_rcvd,
  output logic              bcol,
  output logic              evt,
  output logic [PEND_W-1:0] pend,
  output logic              start_seen,
  output logic              stop_seen,
  output logic              bus_free
);

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       qtick, run, sda_s, start_det, stop_det;
  logic [1:0] q;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  i2cm_bus_mon #(.SYNC(SYNC)) i_mon (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en         (en),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s      (sda_s),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .bus_free   (bus_free)
  );

  i2cm_phase_gen #(.DIV_W(DIV_W)) i_phase (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (run),
    .div   (clk_div),
    .qtick (qtick),
    .q     (q)
  );

  i2cm_engine #(.DATA_W(DATA_W)) i_eng (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en          (en),
    .qtick       (qtick),
    .q           (q),
    .sda_s       (sda_s),
    .bus_free    (bus_free),
    .stop_det    (stop_det),
    .cmd_start   (cmd_start),
    .cmd_rstart  (cmd_rstart),
    .cmd_stop    (cmd_stop),
    .cmd_ack     (cmd_ack),
    .ack_bit     (ack_bit),
    .tx_wr       (tx_wr),
    .tx_data     (tx_data),
    .stop_irq_en (stop_irq_en),
    .evt_clr     (evt_clr),
    .bcol_clr    (bcol_clr),
    .run         (run),
    .scl_low     (scl_oe),
    .sda_low     (sda_oe),
    .bus_own     (bus_own),
    .buf_full    (buf_full),
    .ack_rcvd    (ack_rcvd),
    .bcol        (bcol),
    .evt         (evt),
    .pend        (pend)
  );

  assign busy = run;

  // start_det is used only by the checker-visible seen flags; keep it referenced
  logic unused_ok;
  assign unused_ok = start_det;

endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy,
  input logic       bus_own,
  input logic       buf_full,
  input logic       bcol,
  input logic [3:0] pend,
  input logic       start_seen,
  input logic       stop_seen,
  input logic       bus_free
);

  // R5: losing arbitration leaves both lines released and the bus unowned
  a_r5_coll_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcol) |-> (!scl_oe && !sda_oe && !bus_own));

  // R5 / R6: losing arbitration clears pending commands and the buffer flag
  a_r6_coll_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcol) |-> (pend == 4'd0 && !buf_full));

  // R8: no Start while the collision flag is held
  a_r8_no_start_on_bcol: assert property (@(posedge clk) disable iff (!rst_n)
    (bcol && !bus_own) |=> !bus_own);

  // R2: ownership is taken only from a free bus
  a_r2_take_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> $past(bus_free));

  // R10: disable ends transfers and clears condition tracking
  a_r10_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bus_own && !buf_full && !start_seen && !stop_seen && pend == 4'd0));

  // R6: at most one command pending
  a_r6_pend_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend));

  // R4: a full buffer means a byte sequence is running
  a_r4_buf_busy: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> busy);

endmodule

bind i2c_mm_master i2cm_checker i_chk (.*);

// File: tb/test_i2c_mm_master.sv
`timescale 1ns/1ps
module test_i2c_mm_master;

  logic       clk, rst_n, en;
  logic [7:0] clk_div;
  logic       cmd_start, cmd_rstart, cmd_stop, cmd_ack, ack_bit, tx_wr;
  logic [7:0] tx_data;
  logic       stop_irq_en, evt_clr, bcol_clr;
  logic       scl_oe, sda_oe, busy, bus_own, buf_full, ack_rcvd, bcol, evt;
  logic [3:0] pend;
  logic       start_seen, stop_seen, bus_free;

  logic oth_sda, slv_sda, slv_en;
  logic scl_bus, sda_bus;
  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe || oth_sda || slv_sda);

  int checks = 0;
  int fails  = 0;

  i2c_mm_master i_i2c_mm_master (
    .clk(clk), .rst_n(rst_n), .en(en), .clk_div(clk_div),
    .scl_i(scl_bus), .sda_i(sda_bus),
    .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
    .cmd_ack(cmd_ack), .ack_bit(ack_bit), .tx_wr(tx_wr), .tx_data(tx_data),
    .stop_irq_en(stop_irq_en), .evt_clr(evt_clr), .bcol_clr(bcol_clr),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .bus_own(bus_own),
    .buf_full(buf_full), .ack_rcvd(ack_rcvd), .bcol(bcol), .evt(evt),
    .pend(pend), .start_seen(start_seen), .stop_seen(stop_seen),
    .bus_free(bus_free)
  );

  initial clk = 1'b0;
  always #4 clk = !clk;

  // bus observer and acknowledging slave
  logic [15:0] cap;
  int          ncap;
  time         t_rise0, t_rise1;
  always @(posedge scl_bus) begin
    if (ncap == 0) t_rise0 = $time;
    if (ncap == 1) t_rise1 = $time;
    cap  <= {cap[14:0], sda_bus};
    ncap <= ncap + 1;
  end
  always @(negedge scl_bus) begin
    slv_sda <= (ncap == 8) && slv_en;
  end

  localparam logic [8:0] VEC [0:3] = '{9'h1A5, 9'h03C, 9'h1FF, 9'h000};

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) cmd_start = 1'b1;
    @(negedge clk) cmd_start = 1'b0;
  endtask

  task automatic do_start();
    pulse_start();
    while (!(bus_own && !busy)) @(negedge clk);
  endtask

  task automatic do_rstart();
    @(negedge clk) cmd_rstart = 1'b1;
    @(negedge clk) cmd_rstart = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic do_stop();
    @(negedge clk) cmd_stop = 1'b1;
    @(negedge clk) cmd_stop = 1'b0;
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    ncap = 0;
    cap  = '0;
    tx_data = d;
    tx_wr   = 1'b1;
    @(negedge clk) tx_wr = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic clr_evt();
    @(negedge clk) evt_clr = 1'b1;
    @(negedge clk) evt_clr = 1'b0;
  endtask

  task automatic clr_bcol();
    @(negedge clk) bcol_clr = 1'b1;
    @(negedge clk) bcol_clr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; clk_div = 8'd3;
    cmd_start = 0; cmd_rstart = 0; cmd_stop = 0; cmd_ack = 0; ack_bit = 0;
    tx_wr = 0; tx_data = '0; stop_irq_en = 0; evt_clr = 0; bcol_clr = 0;
    oth_sda = 0; slv_sda = 0; slv_en = 0; ncap = 0; cap = '0;
    t_rise0 = 0; t_rise1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 scl_oe", scl_oe, 0);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 flags", {bcol, evt, buf_full, pend}, 0);
    check("R1 bus_free", bus_free, 1);

    // R4 / R11 / R2: vector table of bytes and slave responses
    for (int i = 0; i < 4; i++) begin
      clr_evt();
      do_start();
      check("R11 evt after start", evt, 1);
      check("R3 start_seen after own start", start_seen, 1);
      slv_en = VEC[i][8];
      do_write(VEC[i][7:0]);
      check("R4 bus byte", int'(cap[8:1]), int'(VEC[i][7:0]));
      check("R4 ack slot level", cap[0], !VEC[i][8]);
      check("R4 ack_rcvd", ack_rcvd, VEC[i][8]);
      check("R4 bit period ns", int'(t_rise1 - t_rise0), 128);
      slv_en = 0;
      do_stop();
      check("R2 bus_free after stop", bus_free, 1);
      check("R3 stop_seen", stop_seen, 1);
      check("R11 released", {bus_own, scl_oe, sda_oe}, 0);
    end

    // R2 / R3: bus held by another master, Start waits
    @(negedge clk) oth_sda = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 foreign start seen", {start_seen, stop_seen}, 2'b10);
    check("R2 bus busy", bus_free, 0);
    pulse_start();
    repeat (60) @(negedge clk);
    check("R2 start held pending", pend, 4'b0001);
    check("R2 not owned", bus_own, 0);
    @(negedge clk) oth_sda = 1'b0;
    while (!(bus_own && !busy)) @(negedge clk);
    check("R2 start after stop", bus_own, 1);
    clr_evt();
    do_rstart();
    check("R11 rstart done", {evt, pend, bus_own}, {1'b1, 4'b0000, 1'b1});
    do_stop();

    // R5 / R7 / R8 / R9: collision on the first data bit
    do_start();
    clr_evt();
    @(negedge clk) oth_sda = 1'b1;
    do_write(8'hA5);
    check("R5 bcol", bcol, 1);
    check("R5 lines released", {scl_oe, sda_oe, bus_own}, 0);
    check("R5 buf/pend cleared", {buf_full, pend}, 0);
    check("R7 no evt before stop", evt, 0);
    @(negedge clk) oth_sda = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 evt on stop after collision", evt, 1);
    check("R2 free again", bus_free, 1);
    pulse_start();
    repeat (60) @(negedge clk);
    check("R8 no start with bcol", {bus_own, bcol}, 2'b01);
    clr_bcol();
    while (!(bus_own && !busy)) @(negedge clk);
    check("R8 bcol cleared", bcol, 0);
    slv_en = 1;
    do_write(8'hC3);
    slv_en = 0;
    check("R9 restarts at MSB", int'(cap[8:1]), 8'hC3);
    do_stop();

    // R6: collision during a Start
    @(negedge clk) begin cmd_start = 1'b1; oth_sda = 1'b1; end
    @(negedge clk) cmd_start = 1'b0;
    repeat (20) @(negedge clk);
    check("R6 start collision", {bcol, bus_own, pend}, {1'b1, 1'b0, 4'b0000});
    @(negedge clk) oth_sda = 1'b0;
    repeat (6) @(negedge clk);
    clr_bcol();

    // R6: collision on a released acknowledge bit
    do_start();
    do_write(8'h5A);
    @(negedge clk) begin oth_sda = 1'b1; ack_bit = 1'b1; cmd_ack = 1'b1; end
    @(negedge clk) cmd_ack = 1'b0;
    while (busy) @(negedge clk);
    check("R6 ack collision", {bcol, bus_own, pend}, {1'b1, 1'b0, 4'b0000});
    @(negedge clk) oth_sda = 1'b0;
    repeat (6) @(negedge clk);
    clr_bcol();

    // R10: disable mid-byte
    do_start();
    @(negedge clk) begin tx_data = 8'hFF; tx_wr = 1'b1; end
    @(negedge clk) tx_wr = 1'b0;
    repeat (40) @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 terminated", {bus_own, buf_full, scl_oe, sda_oe}, 0);
    check("R10 seen cleared", {start_seen, stop_seen, bus_free}, 3'b001);
    en = 1'b1;
    repeat (10) @(negedge clk);

    // R7: stop interrupt enabled while a foreign transfer runs
    @(negedge clk) oth_sda = 1'b1;
    repeat (6) @(negedge clk);
    clr_evt();
    stop_irq_en = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 no evt while busy", evt, 0);
    @(negedge clk) oth_sda = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 evt on foreign stop", evt, 1);
    stop_irq_en = 1'b0;

    finish_run();
  end

endmodule